// File: doc/BRIEF.md
# Supply Voltage Supervisor Controller

This block is the digital side of an on-chip supply voltage supervisor. An analog comparator outside the block compares the supply against a threshold and presents the result as one asynchronous bit. The block chooses the threshold code and tells the analog side whether the falling or the rising threshold applies. It also waits out a settling period after enable. It can optionally filter the comparator through a separate, slow sampling clock. From the result it keeps a ready flag and a level flag, and it raises an interrupt pulse, a held reset, or both.

Configuration is held in three small registers that are written through a simple write port. Address 0 holds the enable in bit 0. Address 1 is the mode register: operating mode in bits [1:0], function select in bits [3:2] and sampling enable in bit 4. Address 2 holds the 4-bit level code in bits [3:0]. The comparator input is 1 while the supply is below the applied threshold.

Top module: `svs_ctrl`

## Requirements
- R1: After reset all configuration fields are 0. A write to address 2 sets the level code, and `lvl_code_o` shows its bits [3:0] from the cycle after the write.
- R2: The supervisor runs only while the enable bit is 1 and the operating mode is 2 or 3. With mode 0 or 1 the ready flag stays 0.
- R3: With sampling off, `ready_o` rises exactly SETTLE_CYC+1 clock edges after the edge that registers the enable write.
- R4: With sampling on (mode bit 4 = 1), `ready_o` rises only once the settle count is complete and three sampling clock rising edges have then been seen.
- R5: While `ready_o` is 0, `lvl_o`, `irq_o` and `rst_o` are 0, whatever the comparator shows.
- R6: With sampling off and ready set, a change on `cmp_i` appears on `lvl_o` on the fourth clock edge after the change: two synchronizer stages, one filter stage and one flag stage.
- R7: With sampling on, `lvl_o` changes only after the synchronized comparator has shown the same value on three consecutive sampling edges. A single differing sample leaves it unchanged.
- R8: When function bit 0 (mode bit 2) is 1, `irq_o` is a one-cycle pulse in the first cycle of each 0-to-1 change of `lvl_o`. When that bit is 0, no pulse occurs.
- R9: When function bit 1 (mode bit 3) is 1, `rst_o` is high exactly while `lvl_o` is 1, and it is released when the level flag clears.
- R10: Clearing the enable bit clears `ready_o`, `lvl_o` and `rst_o` within two clock edges of the write and restarts the settle count.
- R11: `thr_sel_o` is 0 (falling threshold) while `lvl_o` is 0 and 1 (rising threshold) while `lvl_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register address (0 enable, 1 mode, 2 level) |
| cfg_wdata_i | input | 8 | Write data |
| cmp_i | input | 1 | Asynchronous comparator result, 1 = supply below threshold |
| smp_clk_i | input | 1 | Asynchronous sampling clock |
| lvl_code_o | output | 4 | Detection level code to the analog side |
| thr_sel_o | output | 1 | Threshold select: 0 falling, 1 rising |
| ready_o | output | 1 | Detection result settled |
| lvl_o | output | 1 | Level flag: supply below threshold |
| irq_o | output | 1 | One-cycle detection interrupt |
| rst_o | output | 1 | Held detection reset |

## Verification
The comparator is driven in three ways. Directed single steps measure the exact flag latency and the settle count. A long random sequence of held levels, with sampling off, checks that every rise gives exactly one interrupt and that the flag always follows the input. Sampling-clock pulse trains carry an isolated opposite sample, which separates true three-sample agreement from plain edge-triggered sampling. Enabling while the comparator already reports low supply shows whether masking before ready holds. Toggling the function bits shows whether interrupt and reset are gated apart.

// File: rtl/svs_pkg.sv
// Package: shared register addresses and the configuration record for the
// supply voltage supervisor controller. Assumes an 8-bit write data path.
package svs_pkg;
    localparam int LVL_W  = 4;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_MODE  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_LEVEL = 2'd2;

    typedef struct packed {
        logic             en;
        logic [1:0]       op_mode;
        logic [1:0]       func;
        logic             smp_on;
        logic [LVL_W-1:0] level;
    } svs_cfg_t;
endpackage

// File: rtl/svs_regs.sv
// Module: configuration register set. Decodes single-cycle writes into the
// enable, mode and level fields. Assumes writes are synchronous to clk.
module svs_regs
    import svs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output svs_cfg_t          cfg_o
);
    svs_cfg_t cfg_q;

    // Register update on a decoded write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we_i) begin
            case (addr_i)
                ADR_CTRL:  cfg_q.en <= wdata_i[0];
                ADR_MODE: begin
                    cfg_q.op_mode <= wdata_i[1:0];
                    cfg_q.func    <= wdata_i[3:2];
                    cfg_q.smp_on  <= wdata_i[4];
                end
                ADR_LEVEL: cfg_q.level <= wdata_i[LVL_W-1:0];
                default: ;
            endcase
        end
    end

    assign cfg_o = cfg_q;

    // R1
    level_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADR_LEVEL) |=> cfg_q.level == $past(wdata_i[LVL_W-1:0]));
endmodule

// File: rtl/svs_cmp_filter.sv
// Module: comparator front end. Synchronizes the asynchronous comparator bit
// and the sampling clock, then either passes the comparator through or
// requires AGREE consecutive equal samples on sampling clock rising edges.
// Assumes the sampling clock is much slower than clk.
module svs_cmp_filter #(
    parameter int AGREE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic smp_on_i,
    input  logic cmp_async_i,
    input  logic smp_clk_async_i,
    output logic smp_tick_o,
    output logic filt_o
);
    logic [1:0]       cmp_sync_q;
    logic [2:0]       sclk_sync_q;
    logic [AGREE-1:0] hist_q;
    logic [AGREE-1:0] hist_n;
    logic             filt_q;
    logic             cmp_s;
    logic             tick;

    // Two-flop synchronizer for the comparator result
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_sync_q <= '0;
        else        cmp_sync_q <= {cmp_sync_q[0], cmp_async_i};
    end

    // Synchronizer plus history flop for sampling clock edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_sync_q <= '0;
        else        sclk_sync_q <= {sclk_sync_q[1:0], smp_clk_async_i};
    end

    assign cmp_s  = cmp_sync_q[1];
    assign tick   = sclk_sync_q[1] & ~sclk_sync_q[2];
    assign hist_n = {hist_q[AGREE-2:0], cmp_s};

    // Sample history and filtered level
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            hist_q <= '0;
            filt_q <= 1'b0;
        end else if (!smp_on_i) begin
            filt_q <= cmp_s;
        end else if (tick) begin
            hist_q <= hist_n;
            if (&hist_n)       filt_q <= 1'b1;
            else if (~|hist_n) filt_q <= 1'b0;
        end
    end

    assign smp_tick_o = tick;
    assign filt_o     = filt_q;

    // R7
    smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && smp_on_i && !tick) |=> $stable(filt_q));
    // R6
    nosmp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !smp_on_i) |=> filt_q == $past(cmp_sync_q[1]));
endmodule

// File: rtl/svs_settle_timer.sv
// Module: settling timer. Counts SETTLE_CYC clocks after activation, then,
// if sampling is on, waits for SMP_EDGES sampling ticks before asserting
// ready. Deactivation clears everything. Assumes SETTLE_CYC >= 1.
module svs_settle_timer #(
    parameter int SETTLE_CYC = 75000,
    parameter int SMP_EDGES  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic smp_on_i,
    input  logic smp_tick_i,
    output logic ready_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam int TCK_W = $clog2(SMP_EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE_CYC);
    localparam logic [TCK_W-1:0] TCK_END = TCK_W'(SMP_EDGES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [TCK_W-1:0] tck_q;
    logic             ready_q;

    // Settle count, then sampling edge count, then ready
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            cnt_q   <= '0;
            tck_q   <= '0;
            ready_q <= 1'b0;
        end else if (cnt_q != CNT_END) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (!ready_q) begin
            if (!smp_on_i) begin
                ready_q <= 1'b1;
            end else if (smp_tick_i) begin
                if (tck_q == TCK_END) ready_q <= 1'b1;
                else                  tck_q   <= tck_q + 1'b1;
            end
        end
    end

    assign ready_o = ready_q;

    // R3
    ready_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |-> cnt_q == CNT_END);
    // R4
    smp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && smp_on_i && !ready_q && !smp_tick_i) |=> !ready_q);
    // R10
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !ready_q);
endmodule

// File: rtl/svs_ctrl.sv
// Module: supply voltage supervisor controller top. Holds the configuration,
// runs the settling timer and comparator filter, and produces the level flag,
// interrupt pulse, held reset and threshold select. Assumes the comparator
// and sampling clock inputs are asynchronous to clk.
module svs_ctrl
    import svs_pkg::*;
#(
    parameter int SETTLE_CYC  = 75000,
    parameter int AGREE_EDGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              cmp_i,
    input  logic              smp_clk_i,
    output logic [LVL_W-1:0]  lvl_code_o,
    output logic              thr_sel_o,
    output logic              ready_o,
    output logic              lvl_o,
    output logic              irq_o,
    output logic              rst_o
);
    svs_cfg_t cfg;
    logic     active;
    logic     smp_tick;
    logic     filt;
    logic     ready;
    logic     lvl_d;
    logic     lvl_q;
    logic     irq_q;
    logic     rst_q;

    svs_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg)
    );

    // Supervisor mode needs enable and an operating mode of 2 or 3
    assign active = cfg.en & cfg.op_mode[1];

    svs_cmp_filter #(.AGREE(AGREE_EDGES)) u_filt (
        .clk             (clk),
        .rst_n           (rst_n),
        .active_i        (active),
        .smp_on_i        (cfg.smp_on),
        .cmp_async_i     (cmp_i),
        .smp_clk_async_i (smp_clk_i),
        .smp_tick_o      (smp_tick),
        .filt_o          (filt)
    );

    svs_settle_timer #(.SETTLE_CYC(SETTLE_CYC), .SMP_EDGES(AGREE_EDGES)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .smp_on_i   (cfg.smp_on),
        .smp_tick_i (smp_tick),
        .ready_o    (ready)
    );

    // Next level flag: masked until ready
    assign lvl_d = active & ready & filt;

    // Level flag, interrupt pulse and held reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            irq_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
            irq_q <= cfg.func[0] & lvl_d & ~lvl_q;
            rst_q <= cfg.func[1] & lvl_d;
        end
    end

    assign lvl_code_o = cfg.level;
    assign thr_sel_o  = lvl_q;
    assign ready_o    = ready;
    assign lvl_o      = lvl_q;
    assign irq_o      = irq_q;
    assign rst_o      = rst_q;

    // R5
    mask_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> (!lvl_o && !irq_o && !rst_o));
    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R8
    irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (lvl_o && !$past(lvl_o)));
    // R9
    rst_with_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |-> lvl_o);
    // R2
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.op_mode[1] |=> !ready_o);
endmodule

// File: tb/svs_ctrl_tb.sv
module svs_ctrl_tb_top;
    localparam int SETTLE = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       cmp = 1'b0;
    logic       smp_clk = 1'b0;
    logic [3:0] lvl_code;
    logic       thr_sel, ready, lvl, irq, rst_out;

    int checks = 0;
    int fails  = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    svs_ctrl #(.SETTLE_CYC(SETTLE), .AGREE_EDGES(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
        .cfg_wdata_i(cfg_wdata), .cmp_i(cmp), .smp_clk_i(smp_clk),
        .lvl_code_o(lvl_code), .thr_sel_o(thr_sel), .ready_o(ready),
        .lvl_o(lvl), .irq_o(irq), .rst_o(rst_out)
    );

    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    function automatic logic [7:0] mode_word(input int op, input int fn, input bit smp);
        return {3'b000, smp, 2'(fn), 2'(op)};
    endfunction

    // Expected settled level: flag shows the comparator once ready
    function automatic logic exp_lvl(input logic rdy, input logic c);
        return rdy & c;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic spulse(input logic v);
        cmp = v;
        cyc(2);
        smp_clk = 1'b1;
        cyc(4);
        smp_clk = 1'b0;
        cyc(4);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int rises;
        logic prev;
        void'($urandom(32'h5a17));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 reset", {lvl_code, thr_sel, ready, lvl, irq}, 8'h0);
        chk("R9 reset", rst_out, 0);
        wr(2'd2, 8'hfa);
        chk("R1 level code", lvl_code, 4'ha);

        // R2 mode 1 never becomes ready
        cmp = 1'b1;
        wr(2'd1, mode_word(1, 1, 0));
        wr(2'd0, 8'h01);
        cyc(SETTLE + 10);
        chk("R2 mode1 ready", ready, 0);
        wr(2'd0, 8'h00);

        // R3/R5 settle with comparator already low-supply
        wr(2'd1, mode_word(2, 1, 0));
        irq_cnt = 0;
        wr(2'd0, 8'h01);
        cyc(SETTLE);
        chk("R3 not ready yet", ready, 0);
        chk("R5 masked", {lvl, irq, rst_out}, 0);
        cyc(1);
        chk("R3 ready", ready, 1);
        cyc(1);
        chk("R6 lvl after ready", lvl, exp_lvl(ready, cmp));
        chk("R8 irq pulse", irq, 1);
        chk("R11 rising threshold", thr_sel, 1);
        cyc(1);
        chk("R8 irq one cycle", irq, 0);

        // R6 exact latency on a falling comparator
        cmp = 1'b0;
        cyc(3);
        chk("R6 before latency", lvl, 1);
        cyc(1);
        chk("R6 after latency", lvl, 0);
        chk("R11 falling threshold", thr_sel, 0);

        // R6/R8 random held levels
        irq_cnt = 0;
        rises = 0;
        prev = 1'b0;
        for (int i = 0; i < 60; i++) begin
            logic v;
            v = 1'($urandom_range(0, 1));
            if (v && !prev) rises++;
            prev = v;
            cmp = v;
            cyc(6 + $urandom_range(0, 6));
            chk("R6 random follow", lvl, exp_lvl(1'b1, v));
            chk("R11 random thr", thr_sel, v);
        end
        chk("R8 irq count", irq_cnt, 8'(rises));

        // R9 reset function, no interrupt
        cmp = 1'b0;
        cyc(6);
        wr(2'd1, mode_word(2, 2, 0));
        irq_cnt = 0;
        cmp = 1'b1;
        cyc(6);
        chk("R9 rst held", rst_out, 1);
        chk("R8 no irq when disabled", irq_cnt, 0);
        cmp = 1'b0;
        cyc(6);
        chk("R9 rst released", rst_out, 0);
        cmp = 1'b1;
        cyc(6);
        chk("R9 rst again", rst_out, 1);

        // R10 disable clears
        wr(2'd0, 8'h00);
        cyc(1);
        chk("R10 cleared", {ready, lvl, rst_out}, 0);

        // R4 sampling delays ready
        cmp = 1'b0;
        wr(2'd1, mode_word(3, 3, 1));
        wr(2'd0, 8'h01);
        cyc(SETTLE + 6);
        chk("R4 waits for samples", ready, 0);
        spulse(1'b0);
        spulse(1'b0);
        chk("R4 two samples", ready, 0);
        spulse(1'b0);
        chk("R4 three samples", ready, 1);
        chk("R7 lvl low", lvl, 0);

        // R7 three agreeing samples needed
        spulse(1'b1);
        spulse(1'b1);
        chk("R7 two samples", lvl, 0);
        spulse(1'b1);
        chk("R7 three samples", lvl, 1);
        chk("R9 rst in sampling", rst_out, 1);
        spulse(1'b0);
        spulse(1'b1);
        spulse(1'b0);
        spulse(1'b0);
        chk("R7 isolated sample ignored", lvl, 1);
        spulse(1'b0);
        chk("R7 release", lvl, 0);
        chk("R9 release sampling", rst_out, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule